// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

This block gives several processor cores a common set of 32 hardware locks. Each core reaches the bank over its own simple 32-bit register port. The locks sit one word apart, so lock i answers at byte offset 4*i from the bank base.

To claim a lock, a core writes a word with bit 31 set and its core number in the field that starts at bit 8. It then reads the same word back. The claim succeeded only if the value read equals the value written. To free a lock, the owning core writes its core number with bit 31 clear.

The bank records the owner of every held lock. It settles same-cycle claims by fixed port priority. It also drives a vector that shows which locks are held. A core that loses a claim retries in software, so the bank keeps no queue and does no retry of its own.

Each port accepts one request per cycle. The port has no back-pressure: there is no ready signal, and a request that is presented with `bus_valid` high is consumed at that clock edge. A read response arrives exactly one cycle later, flagged by `rsp_valid`. The requester must take the response in that cycle, because it is not held.

Top module: `sem_bank`

## Requirements
- R1: After reset, all 32 locks are free. `lock_held` is all zero and every lock reads as 0.
- R2: Address decoding works as follows:
  - Byte address bits [AW-1:2] select the lock word, and bits [1:0] are ignored.
  - A word index of 32 or more (byte offset 0x80 and up) reads as 0.
  - A write to such an index changes no lock.
- R3: A write with bit 31 set is a take. When the addressed lock is free, the take stores bit 31 and the core number from bits [8+IDW-1:8], and the lock reads as held from the next cycle on.
- R4: A take to a lock that is already held is ignored. The lock keeps the earlier owner's value.
- R5: A write with bit 31 clear is a release. If its core number equals the stored owner, the lock returns to 0. If the core number differs, or the lock is free, the write is ignored.
- R6: A read gets its response in the next cycle. `rsp_valid` is high for that one cycle only.
  - The data is 0 for a free lock.
  - For a held lock, the data is 0x8000_0000 OR'd with the owner shifted left by 8.
  - `rsp_data` is 0 whenever `rsp_valid` is low, and writes raise no response.
- R7: When several ports take the same free lock in one cycle, the lowest port index wins. The other takes are ignored.
- R8: A read that arrives in the same cycle as a write to the same lock returns the value from before that write.
- R9: `lock_held[i]` is 1 exactly while lock i is held. It changes in the cycle after the write that takes or frees the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | NPORT | Per-port request strobe |
| bus_write | input | NPORT | Per-port request type: 1 is a write, 0 is a read |
| bus_addr | input | NPORT*AW | Per-port byte address, with port p in bits [p*AW +: AW] |
| bus_wdata | input | NPORT*32 | Per-port write data |
| rsp_valid | output | NPORT | Per-port read response strobe, one cycle after the read |
| rsp_data | output | NPORT*32 | Per-port read data |
| lock_held | output | NLOCK | Held status, one bit per lock |

## Verification
All results are due one clock after the request that causes them:
- Read data appears on `rsp_data` at the first edge after the read.
- A take or release shows on `lock_held` at the first edge after the write.
- A read back issued in the following cycle therefore sees the new state.

A reference model in the bench is updated on each rising edge from the inputs that were present at that edge. It compares `lock_held`, `rsp_valid` and `rsp_data` at the next falling edge, which is exactly one register stage after the stimulus. Directed read-backs sample at that same falling edge. This covers:
- same-cycle contention;
- a read that meets a write to the same lock in one cycle;
- aliasing through the low address bits;
- the window beyond 32 words.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int WORD_W   = 32;
  localparam int FLAG_BIT = 31;
  localparam int ID_LSB   = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_READ = 2'd1,
    OP_TAKE = 2'd2,
    OP_FREE = 2'd3
  } sem_op_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
#(
  parameter int NLOCK = 32,
  parameter int AW    = 8,
  parameter int IDW   = 4,
  localparam int IW   = $clog2(NLOCK)
) (
  input  logic              valid,
  input  logic              write,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output sem_op_e           op,
  output logic              in_range,
  output logic [IW-1:0]     idx,
  output logic [IDW-1:0]    id
);
  logic unused_bits;

  assign in_range = int'(addr[AW-1:2]) < NLOCK;
  assign idx      = addr[2 +: IW];
  assign id       = wdata[ID_LSB +: IDW];

  always_comb begin
    if (!valid)              op = OP_NONE;
    else if (!write)         op = OP_READ;
    else if (wdata[FLAG_BIT]) op = OP_TAKE;
    else                     op = OP_FREE;
  end

  assign unused_bits = ^{addr[1:0], wdata};
endmodule

// File: rtl/sem_lock_cell.sv
module sem_lock_cell #(
  parameter int NPORT = 2,
  parameter int IDW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORT-1:0]     take_req,
  input  logic [NPORT-1:0]     rel_req,
  input  logic [NPORT*IDW-1:0] req_id,
  output logic                 held,
  output logic [IDW-1:0]       owner
);
  logic [NPORT-1:0] rel_match;
  logic             rel_hit;
  logic             win_found;
  logic [IDW-1:0]   win_id;

  for (genvar p = 0; p < NPORT; p++) begin : g_match
    assign rel_match[p] = rel_req[p] && (req_id[p*IDW +: IDW] == owner);
  end
  assign rel_hit = |rel_match;

  // fixed priority: lowest port index wins
  always_comb begin
    win_found = 1'b0;
    win_id    = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (take_req[p]) begin
        win_found = 1'b1;
        win_id    = req_id[p*IDW +: IDW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (held) begin
      if (rel_hit) begin
        held  <= 1'b0;
        owner <= '0;
      end
    end else if (win_found) begin
      held  <= 1'b1;
      owner <= win_id;
    end
  end

  // R3
  take_sets_chk: assert property (@(posedge clk) disable iff (rst)
    !held && (|take_req) |=> held);
  // R4
  held_keeps_owner_chk: assert property (@(posedge clk) disable iff (rst)
    held && (|take_req) && !rel_hit |=> held && $stable(owner));
  // R5
  release_clears_chk: assert property (@(posedge clk) disable iff (rst)
    held && rel_hit |=> !held && owner == '0);
  // R5
  foreign_release_chk: assert property (@(posedge clk) disable iff (rst)
    held && (|rel_req) && !rel_hit |=> held);
  // R7
  low_port_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !held && take_req[0] |=> owner == $past(req_id[IDW-1:0]));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int NLOCK = 32,
  parameter int AW    = 8,
  parameter int IDW   = 4,
  localparam int IW   = $clog2(NLOCK),
  localparam int PADW = FLAG_BIT - ID_LSB - IDW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        bus_valid,
  input  logic [NPORT-1:0]        bus_write,
  input  logic [NPORT*AW-1:0]     bus_addr,
  input  logic [NPORT*WORD_W-1:0] bus_wdata,
  output logic [NPORT-1:0]        rsp_valid,
  output logic [NPORT*WORD_W-1:0] rsp_data,
  output logic [NLOCK-1:0]        lock_held
);
  sem_op_e              dec_op  [NPORT];
  logic [NPORT-1:0]     dec_ok;
  logic [IW-1:0]        dec_idx [NPORT];
  logic [NPORT*IDW-1:0] id_flat;

  logic [NPORT-1:0]  take_m [NLOCK];
  logic [NPORT-1:0]  rel_m  [NLOCK];
  logic [IDW-1:0]    owner_v [NLOCK];
  logic [WORD_W-1:0] lock_word [NLOCK];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sem_port_decode #(.NLOCK(NLOCK), .AW(AW), .IDW(IDW)) u_dec (
      .valid    (bus_valid[p]),
      .write    (bus_write[p]),
      .addr     (bus_addr[p*AW +: AW]),
      .wdata    (bus_wdata[p*WORD_W +: WORD_W]),
      .op       (dec_op[p]),
      .in_range (dec_ok[p]),
      .idx      (dec_idx[p]),
      .id       (id_flat[p*IDW +: IDW])
    );

    logic              rv;
    logic [WORD_W-1:0] rd;

    always_ff @(posedge clk) begin
      if (rst) begin
        rv <= 1'b0;
        rd <= '0;
      end else begin
        rv <= (dec_op[p] == OP_READ);
        rd <= (dec_op[p] == OP_READ && dec_ok[p]) ? lock_word[dec_idx[p]] : '0;
      end
    end

    assign rsp_valid[p]                   = rv;
    assign rsp_data[p*WORD_W +: WORD_W]   = rd;

    // R6
    read_answers_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid[p] && !bus_write[p] |=> rsp_valid[p]);
    // R6
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !(bus_valid[p] && !bus_write[p]) |=> !rsp_valid[p] && rsp_data[p*WORD_W +: WORD_W] == '0);
    // R2
    outside_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid[p] && !bus_write[p] && !dec_ok[p] |=> rsp_data[p*WORD_W +: WORD_W] == '0);
  end

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    for (genvar p = 0; p < NPORT; p++) begin : g_req
      assign take_m[i][p] = dec_op[p] == OP_TAKE && dec_ok[p] && dec_idx[p] == IW'(i);
      assign rel_m[i][p]  = dec_op[p] == OP_FREE && dec_ok[p] && dec_idx[p] == IW'(i);
    end

    sem_lock_cell #(.NPORT(NPORT), .IDW(IDW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .take_req (take_m[i]),
      .rel_req  (rel_m[i]),
      .req_id   (id_flat),
      .held     (lock_held[i]),
      .owner    (owner_v[i])
    );

    assign lock_word[i] = lock_held[i]
                        ? {1'b1, {PADW{1'b0}}, owner_v[i], {ID_LSB{1'b0}}}
                        : '0;
  end
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int NP = 2;
  localparam int NL = 32;
  localparam int AW = 8;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    b_valid = '0;
  logic [NP-1:0]    b_write = '0;
  logic [NP*AW-1:0] b_addr  = '0;
  logic [NP*32-1:0] b_wdata = '0;
  logic [NP-1:0]    rsp_valid;
  logic [NP*32-1:0] rsp_data;
  logic [NL-1:0]    lock_held;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  sem_bank #(.NPORT(NP), .NLOCK(NL), .AW(AW), .IDW(IDW)) u0 (
    .clk(clk), .rst(rst), .bus_valid(b_valid), .bus_write(b_write),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .lock_held(lock_held)
  );

  // behavioural reference: lock values and the next response per port
  logic [31:0] m_lock [NL];
  logic [31:0] e_data [NP];
  logic        e_vld  [NP];

  always @(posedge clk) begin
    logic [31:0] pre [NL];
    if (rst) begin
      for (int i = 0; i < NL; i++) m_lock[i] = 0;
      for (int p = 0; p < NP; p++) begin e_vld[p] = 0; e_data[p] = 0; end
    end else begin
      for (int i = 0; i < NL; i++) pre[i] = m_lock[i];
      for (int p = 0; p < NP; p++) begin
        int a;
        a = int'(b_addr[p*AW +: AW]) / 4;
        e_vld[p]  = b_valid[p] && !b_write[p];
        e_data[p] = (e_vld[p] && a < NL) ? pre[a] : 0;
      end
      for (int i = 0; i < NL; i++) begin
        bit taken;
        taken = 0;
        for (int p = 0; p < NP; p++) begin
          int a;
          logic [31:0] d;
          logic [31:0] id;
          a  = int'(b_addr[p*AW +: AW]) / 4;
          d  = b_wdata[p*32 +: 32];
          id = (d >> 8) & ((1 << IDW) - 1);
          if (b_valid[p] && b_write[p] && a == i) begin
            if (pre[i] != 0) begin
              if (!d[31] && (id << 8 | 32'h8000_0000) == pre[i]) m_lock[i] = 0;
            end else if (d[31] && !taken) begin
              m_lock[i] = 32'h8000_0000 | (id << 8);
              taken = 1;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      logic [NL-1:0] eh;
      for (int i = 0; i < NL; i++) eh[i] = m_lock[i][31];
      n_chk++;
      if (lock_held !== eh) begin
        n_bad++;
        $display("FAIL R9 lock_held got %h exp %h", lock_held, eh);
      end
      for (int p = 0; p < NP; p++) begin
        n_chk++;
        if (rsp_valid[p] !== e_vld[p] || rsp_data[p*32 +: 32] !== e_data[p]) begin
          n_bad++;
          $display("FAIL R6 port %0d rsp got %b/%h exp %b/%h", p,
                   rsp_valid[p], rsp_data[p*32 +: 32], e_vld[p], e_data[p]);
        end
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic put(int p, bit v, bit w, int a, logic [31:0] d);
    b_valid[p] = v;
    b_write[p] = w;
    b_addr[p*AW +: AW] = AW'(a);
    b_wdata[p*32 +: 32] = d;
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) put(p, 0, 0, 0, 0);
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(int p, int a, logic [31:0] exp, string tag);
    put(p, 1, 0, a, 0);
    step();
    n_chk++;
    if (rsp_data[p*32 +: 32] !== exp) begin
      n_bad++;
      $display("FAIL %s read port %0d addr %h got %h exp %h", tag, p, a,
               rsp_data[p*32 +: 32], exp);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    n_chk++;
    if (lock_held !== '0) begin
      n_bad++;
      $display("FAIL R1 lock_held got %h exp 0", lock_held);
    end
    rd_chk(0, 20, 0, "R1");
    // R3 take a free lock
    put(0, 1, 1, 12, 32'h8000_0200); step();
    rd_chk(0, 12, 32'h8000_0200, "R3");
    // R4 second take ignored
    put(1, 1, 1, 12, 32'h8000_0500); step();
    rd_chk(1, 12, 32'h8000_0200, "R4");
    // R5 foreign release ignored, owner release frees
    put(1, 1, 1, 12, 32'h0000_0500); step();
    rd_chk(1, 12, 32'h8000_0200, "R5");
    put(0, 1, 1, 12, 32'h0000_0200); step();
    rd_chk(0, 12, 0, "R5");
    // R7 same-cycle contention
    put(0, 1, 1, 28, 32'h8000_0100);
    put(1, 1, 1, 28, 32'h8000_0600); step();
    rd_chk(1, 28, 32'h8000_0100, "R7");
    // R2 window and aliasing
    put(0, 1, 1, 8'h80, 32'h8000_0300); step();
    rd_chk(0, 8'h80, 0, "R2");
    rd_chk(0, 0, 0, "R2");
    rd_chk(1, 8'h1D, 32'h8000_0100, "R2");
    // R8 read alongside a release of the same lock
    put(0, 1, 0, 28, 0);
    put(1, 1, 1, 28, 32'h0000_0100); step();
    n_chk++;
    if (rsp_data[31:0] !== 32'h8000_0100) begin
      n_bad++;
      $display("FAIL R8 got %h exp %h", rsp_data[31:0], 32'h8000_0100);
    end
    rd_chk(0, 28, 0, "R8");
    // mixed traffic on a few locks, checked by the model every cycle
    for (int k = 0; k < 3000; k++) begin
      for (int p = 0; p < NP; p++) begin
        int a;
        logic [31:0] d;
        a = ($urandom % 8 == 0) ? (128 + $urandom % 120) : (4 * ($urandom % 4) + $urandom % 4);
        d = {($urandom % 2 == 0), 19'd0, 4'($urandom % 4), 8'($urandom)};
        put(p, ($urandom % 4) != 0, ($urandom % 2) == 0, a, d);
      end
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule